// File: doc/BRIEF.md
# Guarded Status Register and Write-Access Controller

This block holds the volatile status byte of a clock/calendar device that also has a write-protected memory array. The status byte carries two sticky alarm flags, a write-enable latch, a register-write-enable latch and a power-fail flag. The block also decides, byte by byte, whether a write to the clock/control registers or to the array is accepted. When a write is accepted, it acknowledges the byte and pulses a write strobe. When a write is refused, it stays silent.

Transactions come in on a framed byte bus. A `bus_start` pulse presents the target, the direction and a start address. Each data byte is then marked by `byte_vld`, and a `bus_stop` pulse ends the transaction. The target codes are 0 for the array, 1 for the clock/control registers and 2 for the status register. Any other target, and any read that does not target the status register, leaves the controller idle and gets no acknowledge. An external comparator pulses `alarm_hit`. A `total_loss` pulse marks a power-up after both supplies were lost.

The controller is a five-state machine. IDLE moves to SRD on a status read start, to SWR on a status write start, to CWR on a control write start and to AWR on an array write start. Every state returns to IDLE on `bus_stop`. A new `bus_start` in any state re-enters the state chosen by the new target.

Top module: `sr_guard`

## Requirements
- R1: A pulse on `alarm_hit[i]` sets alarm flag i, and the flag stays set until a status read clears it or `total_loss` arrives. Alarm 1 is status bit 6 and alarm 0 is status bit 5.
- R2: When a status read strobes its last byte (`byte_last`=1), the read clears only those alarm flags that were set at its `bus_start`. A flag raised during the read stays set.
- R3: After reset, status bit 1 (write enable) and status bit 2 (register-write enable) are 0, and `clk_run` is 1.
- R4: A status write takes effect at `bus_stop`. The last byte written decides the effect. 0x02 sets write enable and clears register-write enable. 0x00 clears both. 0x06 sets register-write enable only while write enable is already 1. Any other value, or 0x06 with write enable at 0, changes nothing. Status write bytes are always acknowledged.
- R5: While write enable is 0, control and array write bytes get neither `byte_ack` nor `wr_accept`.
- R6: A control write byte is accepted only while both write enable and register-write enable are 1.
- R7: `total_loss` sets status bit 7 (power-fail), clears both latches and both alarm flags, and drops `clk_run`. The first accepted control write byte clears bit 7 and raises `clk_run`.
- R8: Status bits 4, 3 and 0 always read as 0.
- R9: An array write byte whose address is in the range selected by `bp_code` is refused. The codes are 000 none, 001 the upper quarter, 010 the upper half, 011 the whole array, and 1xx the first 1, 2, 4 or 8 pages of 128 bytes (selected by bits 1:0). The address starts at `bus_addr` and advances by one after each array byte.
- R10: `byte_ack` and `wr_accept` are registered. They are valid in the cycle after the edge that samples `byte_vld`, and they last one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_start | input | 1 | Transaction start pulse |
| bus_stop | input | 1 | Transaction stop pulse |
| bus_tgt | input | 2 | Target: 0 array, 1 clock/control, 2 status |
| bus_wr | input | 1 | 1 for write, sampled with bus_start |
| bus_addr | input | 15 | Start address for array writes |
| byte_vld | input | 1 | Data byte strobe |
| byte_last | input | 1 | Marks the final byte of a read |
| wr_byte | input | 8 | Write data byte |
| alarm_hit | input | 2 | Alarm match pulses |
| total_loss | input | 1 | Power-up after loss of both supplies |
| bp_code | input | 3 | Block-protect code |
| rd_byte | output | 8 | Live status byte |
| byte_ack | output | 1 | Per-byte acknowledge |
| wr_accept | output | 1 | Accepted-write strobe |
| clk_run | output | 1 | Clock counting enable |

## Verification
The timing of each result is fixed:

- **Acknowledges and write strobes:** These are valid one edge after the byte strobe. The bench raises `byte_vld` on a falling edge, lets one rising edge pass and samples on the following falling edge.
- **Latch changes:** These appear one edge after `bus_stop`, so the status byte is checked on the falling edge after the stop pulse.
- **Alarm flags:** A flag is set one edge after its pulse. The clear at the end of a status read is visible one edge after the last byte's strobe. The bench reads `rd_byte` before that edge and again after it.

// File: rtl/sr_guard_pkg.sv
package sr_guard_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_SRD,
        S_SWR,
        S_CWR,
        S_AWR
    } ctl_state_t;

    localparam logic [1:0] TGT_ARRAY = 2'd0;
    localparam logic [1:0] TGT_CLOCK = 2'd1;
    localparam logic [1:0] TGT_STAT  = 2'd2;

    localparam logic [7:0] CODE_CLEAR  = 8'h00;
    localparam logic [7:0] CODE_WEL    = 8'h02;
    localparam logic [7:0] CODE_UNLOCK = 8'h06;
endpackage

// File: rtl/sr_guard_prot.sv
module sr_guard_prot #(
    parameter int ADDR_W = 15,
    parameter int PAGE_W = 7
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        bp_code,
    output logic              locked
);
    localparam int QTR_BASE  = 3 << (ADDR_W - 2);
    localparam int HALF_BASE = 1 << (ADDR_W - 1);

    logic [ADDR_W:0] page_lim;

    always_comb begin
        page_lim = (ADDR_W + 1)'(1) << (PAGE_W + int'(bp_code[1:0]));
        unique case (bp_code)
            3'b000:  locked = 1'b0;
            3'b001:  locked = int'(addr) >= QTR_BASE;
            3'b010:  locked = int'(addr) >= HALF_BASE;
            3'b011:  locked = 1'b1;
            default: locked = {1'b0, addr} < page_lim;
        endcase
    end
endmodule

// File: rtl/sr_guard_status.sv
module sr_guard_status
    import sr_guard_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       total_loss,
    input  logic [1:0] alarm_hit,
    input  logic       rd_snap,
    input  logic       rd_done,
    input  logic       sw_apply,
    input  logic [7:0] sw_val,
    input  logic       cc_accept,
    output logic       wel,
    output logic       rwel,
    output logic       rtcf,
    output logic       clk_run,
    output logic [7:0] status_byte
);
    logic [1:0] al;
    logic [1:0] mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            al      <= '0;
            mask    <= '0;
            wel     <= 1'b0;
            rwel    <= 1'b0;
            rtcf    <= 1'b0;
            clk_run <= 1'b1;
        end else if (total_loss) begin
            al      <= '0;
            mask    <= '0;
            wel     <= 1'b0;
            rwel    <= 1'b0;
            rtcf    <= 1'b1;
            clk_run <= 1'b0;
        end else begin
            if (rd_snap) mask <= al;
            al <= (al & ~(rd_done ? mask : 2'b00)) | alarm_hit;
            if (rd_done) mask <= '0;
            if (sw_apply) begin
                if (sw_val == CODE_CLEAR) begin
                    wel  <= 1'b0;
                    rwel <= 1'b0;
                end else if (sw_val == CODE_WEL) begin
                    wel  <= 1'b1;
                    rwel <= 1'b0;
                end else if (sw_val == CODE_UNLOCK && wel) begin
                    rwel <= 1'b1;
                end
            end
            if (cc_accept) begin
                rtcf    <= 1'b0;
                clk_run <= 1'b1;
            end
        end
    end

    assign status_byte = {rtcf, al[1], al[0], 2'b00, rwel, wel, 1'b0};

    AST_RWEL_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        rwel |-> wel); // R4
    AST_ALARM_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_hit[0] && !total_loss) |=> al[0]); // R1
    AST_FAIL_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        rtcf |-> !clk_run); // R7
    AST_LATE_ALARM_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && !total_loss && !mask[1] && al[1]) |=> al[1]); // R2
endmodule

// File: rtl/sr_guard_ctrl.sv
module sr_guard_ctrl
    import sr_guard_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic [1:0]        bus_tgt,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              byte_vld,
    input  logic              byte_last,
    input  logic [7:0]        wr_byte,
    input  logic              wel,
    input  logic              rwel,
    input  logic              prot_hit,
    output logic [ADDR_W-1:0] ptr,
    output logic              rd_snap,
    output logic              rd_done,
    output logic              sw_apply,
    output logic [7:0]        sw_val,
    output logic              cc_accept,
    output logic              byte_ack,
    output logic              wr_accept
);
    ctl_state_t state, state_nx;
    logic       sw_pend;

    always_comb begin
        state_nx = state;
        if (bus_start) begin
            if (bus_wr) begin
                unique case (bus_tgt)
                    TGT_ARRAY: state_nx = S_AWR;
                    TGT_CLOCK: state_nx = S_CWR;
                    TGT_STAT:  state_nx = S_SWR;
                    default:   state_nx = S_IDLE;
                endcase
            end else begin
                state_nx = (bus_tgt == TGT_STAT) ? S_SRD : S_IDLE;
            end
        end else if (bus_stop) begin
            state_nx = S_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    assign rd_snap   = bus_start && !bus_wr && bus_tgt == TGT_STAT;
    assign rd_done   = byte_vld && byte_last && state == S_SRD;
    assign sw_apply  = bus_stop && state == S_SWR && sw_pend;
    assign cc_accept = byte_vld && state == S_CWR && wel && rwel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_ack  <= 1'b0;
            wr_accept <= 1'b0;
            sw_pend   <= 1'b0;
            sw_val    <= '0;
            ptr       <= '0;
        end else begin
            byte_ack  <= 1'b0;
            wr_accept <= 1'b0;
            if (bus_start || bus_stop) sw_pend <= 1'b0;
            if (bus_start) ptr <= bus_addr;
            if (byte_vld) begin
                unique case (state)
                    S_SRD: byte_ack <= 1'b1;
                    S_SWR: begin
                        byte_ack <= 1'b1;
                        sw_val   <= wr_byte;
                        sw_pend  <= 1'b1;
                    end
                    S_CWR: begin
                        byte_ack  <= wel && rwel;
                        wr_accept <= wel && rwel;
                    end
                    S_AWR: begin
                        byte_ack  <= wel && !prot_hit;
                        wr_accept <= wel && !prot_hit;
                        ptr       <= ptr + 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_LOCKED_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && (state == S_CWR || state == S_AWR) && !wel) |=> !byte_ack); // R5
    AST_CC_NEEDS_RWEL: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && state == S_CWR && !rwel) |=> !wr_accept); // R6
    AST_PROT_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && state == S_AWR && prot_hit) |=> !byte_ack); // R9
    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_accept && !byte_vld) |=> !wr_accept); // R10
endmodule

// File: rtl/sr_guard.sv
module sr_guard
    import sr_guard_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int PAGE_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic [1:0]        bus_tgt,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              byte_vld,
    input  logic              byte_last,
    input  logic [7:0]        wr_byte,
    input  logic [1:0]        alarm_hit,
    input  logic              total_loss,
    input  logic [2:0]        bp_code,
    output logic [7:0]        rd_byte,
    output logic              byte_ack,
    output logic              wr_accept,
    output logic              clk_run
);
    logic [ADDR_W-1:0] ptr;
    logic              prot_hit, rd_snap, rd_done, sw_apply, cc_accept;
    logic              wel, rwel, rtcf;
    logic [7:0]        sw_val;

    sr_guard_prot #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_prot (
        .addr(ptr), .bp_code(bp_code), .locked(prot_hit));

    sr_guard_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
        .bus_tgt(bus_tgt), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .byte_vld(byte_vld), .byte_last(byte_last), .wr_byte(wr_byte),
        .wel(wel), .rwel(rwel), .prot_hit(prot_hit), .ptr(ptr),
        .rd_snap(rd_snap), .rd_done(rd_done), .sw_apply(sw_apply),
        .sw_val(sw_val), .cc_accept(cc_accept), .byte_ack(byte_ack),
        .wr_accept(wr_accept));

    sr_guard_status u_stat (
        .clk(clk), .rst_n(rst_n), .total_loss(total_loss), .alarm_hit(alarm_hit),
        .rd_snap(rd_snap), .rd_done(rd_done), .sw_apply(sw_apply), .sw_val(sw_val),
        .cc_accept(cc_accept), .wel(wel), .rwel(rwel), .rtcf(rtcf),
        .clk_run(clk_run), .status_byte(rd_byte));
endmodule

// File: tb/tb_sr_guard.sv
module tb_sr_guard;
    logic        clk = 1'b0, rst_n = 1'b0;
    logic        bus_start = 0, bus_stop = 0, bus_wr = 0, byte_vld = 0, byte_last = 0;
    logic [1:0]  bus_tgt = 0, alarm_hit = 0;
    logic [14:0] bus_addr = 0;
    logic [7:0]  wr_byte = 0, rd_byte;
    logic        total_loss = 0, byte_ack, wr_accept, clk_run;
    logic [2:0]  bp_code = 0;
    int          errs = 0, checks = 0;
    bit          m_wel = 0, m_rwel = 0, m_rtcf = 0;

    always #5 clk = ~clk;

    sr_guard dut (.*);

    function automatic bit prot_model(input logic [2:0] bp, input int a);
        case (bp)
            3'd0: return 0;
            3'd1: return a >= 24576;
            3'd2: return a >= 16384;
            3'd3: return 1;
            default: return a < (128 * (1 << bp[1:0]));
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic start(input logic [1:0] t, input logic w, input logic [14:0] a);
        @(negedge clk); bus_start = 1; bus_tgt = t; bus_wr = w; bus_addr = a;
        @(negedge clk); bus_start = 0;
    endtask

    task automatic stop();
        @(negedge clk); bus_stop = 1;
        @(negedge clk); bus_stop = 0;
    endtask

    task automatic put(input logic [7:0] d, input logic last);
        @(negedge clk); byte_vld = 1; wr_byte = d; byte_last = last;
        @(negedge clk); byte_vld = 0; byte_last = 0;
    endtask

    task automatic stat_wr(input logic [7:0] d);
        start(2'd2, 1, '0); put(d, 0);
        chk("R4 status ack", byte_ack, 1);
        stop();
        if (d == 8'h00) begin m_wel = 0; m_rwel = 0; end
        else if (d == 8'h02) begin m_wel = 1; m_rwel = 0; end
        else if (d == 8'h06 && m_wel) m_rwel = 1;
        chk("R4 latches", rd_byte[2:1], {m_rwel, m_wel});
        chk("R8 unused bits", {rd_byte[4:3], rd_byte[0]}, 0);
    endtask

    task automatic clk_wr(input logic [7:0] d);
        start(2'd1, 1, '0); put(d, 0);
        chk("R6 ctrl ack", byte_ack, m_wel && m_rwel);
        chk("R10 ctrl strobe", wr_accept, m_wel && m_rwel);
        if (m_wel && m_rwel) m_rtcf = 0;
        chk("R7 fail flag", rd_byte[7], m_rtcf);
        chk("R7 clk_run", clk_run, !m_rtcf);
        stop();
    endtask

    task automatic arr_wr(input logic [2:0] bp, input logic [14:0] a);
        bit e;
        bp_code = bp;
        start(2'd0, 1, a); put(8'hA5, 0);
        e = m_wel && !prot_model(bp, int'(a));
        chk("R9 array ack", byte_ack, e);
        chk("R5 array strobe", wr_accept, e);
        stop();
    endtask

    initial begin
        #2_000_000;
        errs++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1931));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R3 reset status", rd_byte, 8'h00);
        chk("R3 reset clk_run", clk_run, 1);

        // locked writes
        clk_wr(8'h11);                        // R5
        arr_wr(3'd0, 15'h0100);               // R5 no ack with wel=0
        stat_wr(8'h06);                       // R4 out of order unlock ignored
        clk_wr(8'h12);                        // R6
        stat_wr(8'h02);
        clk_wr(8'h13);                        // R6 needs rwel
        stat_wr(8'h06);
        clk_wr(8'h14);                        // R6 accepted
        stat_wr(8'h5A);                       // R4 other value ignored
        stat_wr(8'h00);                       // R4 clear

        // protected array writes at boundaries (R9)
        stat_wr(8'h02);
        arr_wr(3'd1, 15'h5FFF); arr_wr(3'd1, 15'h6000);
        arr_wr(3'd2, 15'h3FFF); arr_wr(3'd2, 15'h4000);
        arr_wr(3'd3, 15'h0000);
        arr_wr(3'd4, 15'h007F); arr_wr(3'd4, 15'h0080);
        arr_wr(3'd7, 15'h03FF); arr_wr(3'd7, 15'h0400);
        // address advance across page boundary (R9)
        bp_code = 3'd4;
        start(2'd0, 1, 15'h007F); put(8'h01, 0);
        chk("R9 first byte protected", byte_ack, 0);
        put(8'h02, 0);
        chk("R9 next byte free", byte_ack, 1);
        stop();

        // alarms (R1, R2)
        @(negedge clk); alarm_hit = 2'b01;
        @(negedge clk); alarm_hit = 2'b00;
        chk("R1 alarm0 set", rd_byte[6:5], 2'b01);
        start(2'd2, 0, '0);
        @(negedge clk); alarm_hit = 2'b10;
        @(negedge clk); alarm_hit = 2'b00;
        chk("R1 alarm1 set mid read", rd_byte[6:5], 2'b11);
        put(8'h00, 1);
        chk("R2 read ack", byte_ack, 1);
        chk("R2 only old flag cleared", rd_byte[6:5], 2'b10);
        stop();
        start(2'd2, 0, '0); put(8'h00, 1); stop();
        chk("R2 second read clears", rd_byte[6:5], 2'b00);

        // total power loss (R7)
        @(negedge clk); total_loss = 1;
        @(negedge clk); total_loss = 0;
        m_wel = 0; m_rwel = 0; m_rtcf = 1;
        chk("R7 after loss", rd_byte, 8'h80);
        chk("R7 clock halted", clk_run, 0);
        stat_wr(8'h02); stat_wr(8'h06);
        clk_wr(8'h00);

        // constrained random mix
        for (int i = 0; i < 150; i++) begin
            int op = $urandom_range(0, 2);
            if (op == 0) begin
                logic [7:0] v;
                case ($urandom_range(0, 3))
                    0: v = 8'h00; 1: v = 8'h02; 2: v = 8'h06;
                    default: v = 8'($urandom);
                endcase
                stat_wr(v);
            end else if (op == 1) begin
                arr_wr(3'($urandom), 15'($urandom));
            end else begin
                clk_wr(8'($urandom));
            end
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule